// File: doc/BRIEF.md
# Prefix-Network Adder-Subtractor with Selectable Carry Topology

This block adds or subtracts two N-bit operands and registers the result. Every bit position first derives a generate term (AND of the operand bits) and a propagate term (XOR of the operand bits). A logarithmic-depth prefix network then combines these terms into the carry for each position. In subtract mode the second operand is inverted bit by bit and the carry into bit zero is forced high, so the same network computes the two's complement difference. The caller's carry input is not used in this mode.

The carry network is picked at elaboration by one parameter, and four layouts are available. The dense layout combines every position at every level and finishes in log2(N) levels. The two-pass layout first reduces with a tree and then fills in the remaining positions, using about 2·log2(N) − 1 levels with small fan-out. The broadcast layout also needs only log2(N) levels but uses fewer cells, and some of its cells drive many consumers. The odd-fill layout runs a dense network over odd positions only, then adds one final level that fills in the even positions. All four layouts build on one associative group-combine function. They are functionally interchangeable, so a caller can choose a layout for timing or area without any change at the ports.

The sum, the carry-out and the optional signed-overflow flag are registered. Each one reflects the inputs present at the previous rising clock edge.

Top module: `pfx_addsub`

## Requirements
- R1: A clock edge with `rst` high clears `sum_q`, `carry_q` and `ovf_q` to zero, whatever the operand inputs are.
- R2: With `sub_en` = 0, the edge after the inputs are presented gives `{carry_q, sum_q}` = `op_a` + `op_b` + `carry_in` (an (N+1)-bit unsigned sum).
- R3: With `sub_en` = 1, the next edge gives `sum_q` = (`op_a` − `op_b`) mod 2^N, and `carry_q` = 1 exactly when `op_a` ≥ `op_b` as unsigned numbers (carry high means no borrow).
- R4: With `sub_en` = 1, the value of `carry_in` has no effect on any output.
- R5: When the overflow flag is enabled, `ovf_q` = 1 exactly when the two addends seen by the adder (`op_a`, and `op_b` inverted if subtracting) have the same sign bit (bit N−1) and `sum_q` bit N−1 differs from that sign.
- R6: The dense, two-pass, broadcast and odd-fill layouts give bit-identical outputs for every input.
- R7: A carry that must travel the full width resolves correctly. Examples: all-ones + 0 with carry-in 1, and all-ones + 1, both give sum 0 with `carry_q` = 1.
- R8: 0 − 1 gives the all-ones result with `carry_q` = 0 and `ovf_q` = 0, whatever `carry_in` is.
- R9: The largest positive signed value + 1 gives the most negative value with `ovf_q` = 1 and `carry_q` = 0.
- R10: With the overflow flag disabled by parameter, `ovf_q` stays 0 and the sum and carry behave as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| op_a | input | N | First operand (minuend when subtracting) |
| op_b | input | N | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| carry_in | input | 1 | Carry into bit zero when adding; not used when subtracting |
| sum_q | output | N | Registered sum or difference |
| carry_q | output | 1 | Registered carry out of bit N−1 |
| ovf_q | output | 1 | Registered signed overflow, 0 when disabled |

## Verification
The bench runs the same operands through one instance of each layout, plus a dense instance with the overflow flag disabled, and compares every instance to a behavioural integer model on every cycle. It aims at carries that must cross every position (all-ones plus one, alternating bit patterns plus a carry-in): a layout with a missing or misrouted combine cell returns the right low bits and a wrong upper sum or carry-out. Subtraction of one from zero and of equal operands exposes a design that lets `carry_in` leak into subtract mode or inverts the borrow sense. Stepping past the signed limits in both directions catches an overflow flag taken from the wrong carry pair.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  // Carry network layout, fixed at elaboration.
  typedef enum logic [1:0] {
    PFX_FULL      = 2'd0,  // every span at every level, log2(N) levels
    PFX_TREE2PASS = 2'd1,  // reduce tree, then fill, bounded fan-out
    PFX_BCAST     = 2'd2,  // divide and broadcast, log2(N) levels
    PFX_ODDFILL   = 2'd3   // dense over odd bits, one final even level
  } pfx_topo_e;

  typedef struct packed {
    logic g;
    logic p;
  } pfx_gp_t;

  // Associative group combine: hi covers the upper span, lo the lower.
  function automatic pfx_gp_t pfx_combine(input pfx_gp_t hi, input pfx_gp_t lo);
    pfx_gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/pfx_gp_stage.sv
module pfx_gp_stage #(
  parameter int N = 32
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         sub_en,
  input  logic         carry_in,
  output logic [N-1:0] bit_g,
  output logic [N-1:0] bit_p,
  output logic         carry0
);

  logic [N-1:0] b_eff;

  always_comb begin
    b_eff  = op_b ^ {N{sub_en}};
    bit_g  = op_a & b_eff;
    bit_p  = op_a ^ b_eff;
    carry0 = sub_en | carry_in;
  end

endmodule

// File: rtl/pfx_tree.sv
module pfx_tree
  import pfx_pkg::*;
#(
  parameter int        N    = 32,
  parameter pfx_topo_e TOPO = PFX_FULL
) (
  input  logic [N-1:0] bit_g,
  input  logic [N-1:0] bit_p,
  input  logic         carry0,
  output logic [N-1:0] grp_g   // grp_g[i] = carry into bit i+1
);

  localparam int LG = $clog2(N);

  pfx_gp_t leaf [N];

  // The incoming carry is folded into position zero, so every prefix
  // already includes it.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      leaf[i].g = bit_g[i];
      leaf[i].p = bit_p[i];
    end
    leaf[0].g = bit_g[0] | (bit_p[0] & carry0);
  end

  if (TOPO == PFX_FULL) begin : g_full
    always_comb begin
      pfx_gp_t cur [N];
      pfx_gp_t nxt [N];
      cur = leaf;
      for (int l = 0; l < LG; l++) begin
        nxt = cur;
        for (int i = 0; i < N; i++) begin
          int j;
          j = i - (1 << l);
          if (j >= 0) nxt[i] = pfx_combine(cur[i], cur[j]);
        end
        cur = nxt;
      end
      for (int i = 0; i < N; i++) grp_g[i] = cur[i].g;
    end
  end else if (TOPO == PFX_TREE2PASS) begin : g_tree2pass
    always_comb begin
      pfx_gp_t cur [N];
      pfx_gp_t nxt [N];
      cur = leaf;
      // reduction pass
      for (int l = 0; l < LG; l++) begin
        nxt = cur;
        for (int i = 0; i < N; i++) begin
          int j;
          j = i - (1 << l);
          if (((i + 1) % (1 << (l + 1))) == 0) nxt[i] = pfx_combine(cur[i], cur[j]);
        end
        cur = nxt;
      end
      // distribution pass
      for (int lv = LG - 2; lv >= 0; lv--) begin
        nxt = cur;
        for (int i = 0; i < N; i++) begin
          int j;
          j = i - (1 << lv);
          if ((((i + 1) % (1 << (lv + 1))) == (1 << lv)) && (i > (1 << lv)))
            nxt[i] = pfx_combine(cur[i], cur[j]);
        end
        cur = nxt;
      end
      for (int i = 0; i < N; i++) grp_g[i] = cur[i].g;
    end
  end else if (TOPO == PFX_BCAST) begin : g_bcast
    always_comb begin
      pfx_gp_t cur [N];
      pfx_gp_t nxt [N];
      cur = leaf;
      for (int l = 0; l < LG; l++) begin
        nxt = cur;
        for (int i = 0; i < N; i++) begin
          int j;
          j = ((i >> l) << l) - 1;
          if (((i >> l) & 1) == 1) nxt[i] = pfx_combine(cur[i], cur[j]);
        end
        cur = nxt;
      end
      for (int i = 0; i < N; i++) grp_g[i] = cur[i].g;
    end
  end else begin : g_oddfill
    always_comb begin
      pfx_gp_t cur [N];
      pfx_gp_t nxt [N];
      cur = leaf;
      // pair odd positions with their even neighbour
      nxt = cur;
      for (int i = 1; i < N; i += 2) nxt[i] = pfx_combine(cur[i], cur[i - 1]);
      cur = nxt;
      // dense network across odd positions
      for (int l = 1; l < LG; l++) begin
        nxt = cur;
        for (int i = 1; i < N; i += 2) begin
          int j;
          j = i - (1 << l);
          if (j >= 0) nxt[i] = pfx_combine(cur[i], cur[j]);
        end
        cur = nxt;
      end
      // final level fills even positions
      nxt = cur;
      for (int i = 2; i < N; i += 2) nxt[i] = pfx_combine(cur[i], cur[i - 1]);
      cur = nxt;
      for (int i = 0; i < N; i++) grp_g[i] = cur[i].g;
    end
  end

endmodule

// File: rtl/pfx_sum_stage.sv
module pfx_sum_stage #(
  parameter int N      = 32,
  parameter bit OVF_EN = 1'b1
) (
  input  logic [N-1:0] bit_p,
  input  logic [N-1:0] grp_g,
  input  logic         carry0,
  output logic [N-1:0] sum_d,
  output logic         carry_d,
  output logic         ovf_d
);

  logic [N-1:0] cvec;  // carry into each position

  always_comb begin
    cvec    = {grp_g[N-2:0], carry0};
    sum_d   = bit_p ^ cvec;
    carry_d = grp_g[N-1];
  end

  if (OVF_EN) begin : g_ovf
    assign ovf_d = cvec[N-1] ^ grp_g[N-1];
  end else begin : g_no_ovf
    assign ovf_d = 1'b0;
  end

endmodule

// File: rtl/pfx_addsub.sv
module pfx_addsub
  import pfx_pkg::*;
#(
  parameter int        N      = 32,
  parameter pfx_topo_e TOPO   = PFX_FULL,
  parameter bit        OVF_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         sub_en,
  input  logic         carry_in,
  output logic [N-1:0] sum_q,
  output logic         carry_q,
  output logic         ovf_q
);

  logic [N-1:0] bit_g, bit_p, grp_g, sum_d;
  logic         carry0, carry_d, ovf_d;

  pfx_gp_stage #(.N(N)) u_gp (
    .op_a     (op_a),
    .op_b     (op_b),
    .sub_en   (sub_en),
    .carry_in (carry_in),
    .bit_g    (bit_g),
    .bit_p    (bit_p),
    .carry0   (carry0)
  );

  pfx_tree #(.N(N), .TOPO(TOPO)) u_tree (
    .bit_g  (bit_g),
    .bit_p  (bit_p),
    .carry0 (carry0),
    .grp_g  (grp_g)
  );

  pfx_sum_stage #(.N(N), .OVF_EN(OVF_EN)) u_sum (
    .bit_p   (bit_p),
    .grp_g   (grp_g),
    .carry0  (carry0),
    .sum_d   (sum_d),
    .carry_d (carry_d),
    .ovf_d   (ovf_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
      ovf_q   <= ovf_d;
    end
  end

endmodule

// File: rtl/pfx_addsub_chk.sv
module pfx_addsub_chk #(
  parameter int N      = 32,
  parameter bit OVF_EN = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic         sub_en,
  input logic         carry_in,
  input logic [N-1:0] sum_q,
  input logic         carry_q,
  input logic         ovf_q
);

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: outputs clear after a reset edge
  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      a_reset_clear_r1: assert (sum_q == '0 && !carry_q && !ovf_q)
        else $error("outputs not cleared by reset");
    end
  end

  p_add_value_r2: assert property (@(posedge clk) disable iff (rst)
    (!sub_en) |=> ({carry_q, sum_q} ==
      ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + {{N{1'b0}}, $past(carry_in)})));

  p_sub_value_r3: assert property (@(posedge clk) disable iff (rst)
    sub_en |=> (sum_q == ($past(op_a) - $past(op_b))));

  // R3 and R4: borrow sense, independent of carry_in
  p_sub_carry_r3: assert property (@(posedge clk) disable iff (rst)
    sub_en |=> (carry_q == ($past(op_a) >= $past(op_b))));

  if (OVF_EN) begin : g_ovf_chk
    p_ovf_flag_r5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (ovf_q == (($past(op_a[N-1]) == ($past(op_b[N-1]) ^ $past(sub_en)))
                          && (sum_q[N-1] != $past(op_a[N-1])))));
  end else begin : g_ovf_off_chk
    p_ovf_off_r10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> !ovf_q);
  end

endmodule

bind pfx_addsub pfx_addsub_chk #(.N(N), .OVF_EN(OVF_EN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_a     (op_a),
  .op_b     (op_b),
  .sub_en   (sub_en),
  .carry_in (carry_in),
  .sum_q    (sum_q),
  .carry_q  (carry_q),
  .ovf_q    (ovf_q)
);

// File: tb/pfx_addsub_tb.sv
module pfx_addsub_tb;
  import pfx_pkg::*;

  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic         rst;
  logic [W-1:0] a, b;
  logic         sub, cin;

  logic [W-1:0] s_full, s_2p, s_bc, s_of, s_nov;
  logic         c_full, c_2p, c_bc, c_of, c_nov;
  logic         v_full, v_2p, v_bc, v_of, v_nov;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  pfx_addsub #(.N(W), .TOPO(PFX_FULL)) u_dut (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .sub_en(sub), .carry_in(cin),
    .sum_q(s_full), .carry_q(c_full), .ovf_q(v_full));

  pfx_addsub #(.N(W), .TOPO(PFX_TREE2PASS)) u_dut_2p (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .sub_en(sub), .carry_in(cin),
    .sum_q(s_2p), .carry_q(c_2p), .ovf_q(v_2p));

  pfx_addsub #(.N(W), .TOPO(PFX_BCAST)) u_dut_bc (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .sub_en(sub), .carry_in(cin),
    .sum_q(s_bc), .carry_q(c_bc), .ovf_q(v_bc));

  pfx_addsub #(.N(W), .TOPO(PFX_ODDFILL)) u_dut_of (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .sub_en(sub), .carry_in(cin),
    .sum_q(s_of), .carry_q(c_of), .ovf_q(v_of));

  pfx_addsub #(.N(W), .TOPO(PFX_FULL), .OVF_EN(1'b0)) u_dut_nov (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .sub_en(sub), .carry_in(cin),
    .sum_q(s_nov), .carry_q(c_nov), .ovf_q(v_nov));

  task automatic chk(input string who, input string tag,
                     input logic [W-1:0] s, input logic c, input logic v,
                     input logic [W-1:0] es, input logic ec, input logic ev);
    n_cmp++;
    if (s !== es || c !== ec || v !== ev) begin
      n_bad++;
      $display("FAIL %s [%s]: sum=%h carry=%b ovf=%b, expected sum=%h carry=%b ovf=%b",
               tag, who, s, c, v, es, ec, ev);
    end
  endtask

  // Drive one operation at a falling edge, check one rising edge later.
  task automatic apply(input logic [W-1:0] ia, input logic [W-1:0] ib,
                       input logic isub, input logic icin, input string tag);
    logic [W:0]   ext;
    logic [W-1:0] bb;
    logic         ev;
    @(negedge clk);
    a = ia; b = ib; sub = isub; cin = icin;
    bb  = isub ? ~ib : ib;
    ext = {1'b0, ia} + {1'b0, bb} + {{W{1'b0}}, (isub | icin)};
    ev  = (ia[W-1] == bb[W-1]) && (ext[W-1] != ia[W-1]);
    @(posedge clk); #1;
    chk("dense",    tag,                 s_full, c_full, v_full, ext[W-1:0], ext[W], ev);
    chk("two-pass", {tag, "/R6"},        s_2p,   c_2p,   v_2p,   ext[W-1:0], ext[W], ev);
    chk("bcast",    {tag, "/R6"},        s_bc,   c_bc,   v_bc,   ext[W-1:0], ext[W], ev);
    chk("odd-fill", {tag, "/R6"},        s_of,   c_of,   v_of,   ext[W-1:0], ext[W], ev);
    chk("no-ovf",   {tag, "/R10"},       s_nov,  c_nov,  v_nov,  ext[W-1:0], ext[W], 1'b0);
  endtask

  task automatic check_reset();
    chk("dense",    "R1", s_full, c_full, v_full, '0, 1'b0, 1'b0);
    chk("two-pass", "R1", s_2p,   c_2p,   v_2p,   '0, 1'b0, 1'b0);
    chk("bcast",    "R1", s_bc,   c_bc,   v_bc,   '0, 1'b0, 1'b0);
    chk("odd-fill", "R1", s_of,   c_of,   v_of,   '0, 1'b0, 1'b0);
    chk("no-ovf",   "R1", s_nov,  c_nov,  v_nov,  '0, 1'b0, 1'b0);
  endtask

  initial begin
    rst = 1'b1; a = '1; b = '1; sub = 1'b0; cin = 1'b1;
    repeat (3) @(posedge clk);
    #1 check_reset();  // R1
    @(negedge clk); rst = 1'b0;

    // R7: full-width carry
    apply('1, '0, 1'b0, 1'b1, "R7");
    apply('1, 16'h0001, 1'b0, 1'b0, "R7");
    apply(16'h5555, 16'hAAAA, 1'b0, 1'b1, "R7");
    apply(16'hAAAA, 16'h5555, 1'b0, 1'b1, "R7");
    // R8: zero minus one, both carry_in values
    apply('0, 16'h0001, 1'b1, 1'b0, "R8");
    apply('0, 16'h0001, 1'b1, 1'b1, "R8");
    // R9 and R5: stepping past the signed limits
    apply(16'h7FFF, 16'h0001, 1'b0, 1'b0, "R9");
    apply(16'h8000, 16'h0001, 1'b1, 1'b0, "R5");
    apply(16'h8000, 16'h8000, 1'b0, 1'b0, "R5");
    apply(16'h7FFF, 16'h8000, 1'b1, 1'b0, "R5");
    // R2 / R3 basics
    apply('0, '0, 1'b0, 1'b0, "R2");
    apply(16'h1234, 16'h1234, 1'b1, 1'b0, "R3");
    apply(16'h0010, 16'h0020, 1'b1, 1'b0, "R3");
    // R4: carry_in flips under subtract must not change results
    for (int k = 0; k < 4; k++) begin
      apply(16'h4C21, 16'h19F7, k[1], k[0], k[1] ? "R4" : "R2");
    end

    // Random operands across all mode combinations
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] ra, rb;
      logic         rs, rc;
      ra = W'($urandom);
      rb = W'($urandom);
      rs = 1'($urandom);
      rc = 1'($urandom);
      apply(ra, rb, rs, rc, rs ? "R3" : "R2");
    end

    // R1: reset in the middle of traffic
    @(negedge clk);
    rst = 1'b1; a = 16'hFFFF; b = 16'h0001; sub = 1'b0; cin = 1'b1;
    @(posedge clk); #1 check_reset();
    @(negedge clk); rst = 1'b0;
    apply(16'h00FF, 16'h0001, 1'b0, 1'b0, "R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule